// File: doc/BRIEF.md
# Free-Running Timer with Prescaler Bypass Test Mode

The block is a free-running up-counter with an overflow flag. It advances on enabled clock cycles through a power-of-two prescaler whose ratio comes from a 3-bit select. The overflow flag stays set until it is cleared by writing 1 to it. Capture and compare units elsewhere in the chip read the count output. Every pin is a plain control or status pin. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

A one-bit test control register, the bypass bit, can be read at any time. It accepts writes only while the special-mode input is high. When the bypass bit is set, the prescaler is skipped and the counter splits into two independent 8-bit halves. Each half advances on every enabled cycle, no carry passes from the low half to the high half, and the overflow flag follows the high half alone. This lets a production test reach the high-byte wrap in 256 cycles instead of 65536 or more.

Top module: `ftmr_top`

## Requirements
- R1: `rd_data` shows the bypass bit at bit 0 at all times, and bits 7..1 always read 0.
- R2: A write with `reg_wr`=1 loads `reg_wdata[0]` into the bypass bit only when `special_mode`=1. Otherwise the write has no effect.
- R3: After reset, `count`=0x0000, `ovf_flag`=0 and the bypass bit is 0.
- R4: With bypass=0, `count` increments by 1 once every 2^`psel` enabled cycles, giving ratios 1 to 128 for `psel` 0 to 7. The prescaler counts only enabled cycles and starts from 0 at reset.
- R5: With bypass=0, `ovf_flag` sets when `count` wraps from 0xFFFF to 0x0000. A wrap of the low byte alone does not set it.
- R6: With bypass=1, bits 15..8 and bits 7..0 each increment by 1 on every enabled cycle, whatever the value of `psel`, with no carry from the low half into the high half.
- R7: With bypass=1, `ovf_flag` sets when bits 15..8 wrap from 0xFF to 0x00.
- R8: While `cnt_en`=0, `count` and the prescaler hold their values.
- R9: `ovf_clr`=1 clears `ovf_flag` at the next edge. If a set occurs in the same cycle, the set wins.
- R10: Changing the bypass bit leaves `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Clock enable for prescaler and counter |
| psel | input | 3 | Prescale select, ratio 2^psel |
| special_mode | input | 1 | Allows writes to the test register |
| reg_wr | input | 1 | Test register write strobe |
| reg_wdata | input | 8 | Test register write data, bit 0 = bypass |
| rd_data | output | 8 | Test register read value |
| count | output | 16 | Current timer count |
| ovf_flag | output | 1 | Overflow flag |
| ovf_clr | input | 1 | Write-1-to-clear strobe for the overflow flag |

## Verification
The bench builds the block with its default parameters: a 16-bit count split into two 8-bit halves, and a 3-bit prescale select with a 7-bit prescaler. Because the bypass mode advances both halves together, 255 bypassed cycles bring the count to 0xFFFF. Switching back to normal mode then reaches the full 16-bit wrap in a single cycle instead of 65536. The largest ratio of 128 shows within a few hundred cycles, and a mixed normal and bypass sequence exposes the missing carry between the halves.

// File: rtl/ftmr_pkg.sv
package ftmr_pkg;
  localparam int unsigned FT_CNT_W  = 16;
  localparam int unsigned FT_HALF_W = 8;
  localparam int unsigned FT_PS_W   = 3;
  localparam int unsigned FT_REG_W  = 8;
  localparam int unsigned FT_BYP_POS = 0;
  typedef logic [FT_PS_W-1:0] ps_sel_t;
endpackage

// File: rtl/ftmr_prescaler.sv
module ftmr_prescaler #(
  parameter int unsigned PS_W = ftmr_pkg::FT_PS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_en,
  input  logic [PS_W-1:0] psel,
  output logic            tick
);
  localparam int unsigned PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   one_sh;
  logic [PRE_W-1:0] mask;

  always_comb begin
    one_sh = (PRE_W+1)'(1) << psel;
    mask   = one_sh[PRE_W-1:0] - PRE_W'(1);
  end

  assign tick = cnt_en && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (cnt_en) pre_q <= pre_q + PRE_W'(1);
  end

  // R8
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(pre_q));
  // R4
  sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && psel == '0) |-> tick);
endmodule

// File: rtl/ftmr_testreg.sv
module ftmr_testreg #(
  parameter int unsigned REG_W   = ftmr_pkg::FT_REG_W,
  parameter int unsigned BYP_POS = ftmr_pkg::FT_BYP_POS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             special_mode,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] rd_data,
  output logic             bypass
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      bypass <= 1'b0;
    else if (reg_wr && special_mode) bypass <= reg_wdata[BYP_POS];
  end

  always_comb begin
    rd_data          = '0;
    rd_data[BYP_POS] = bypass;
  end

  // R2
  locked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !special_mode |=> $stable(bypass));
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_data) <= 1);
endmodule

// File: rtl/ftmr_counter.sv
module ftmr_counter #(
  parameter int unsigned CNT_W  = ftmr_pkg::FT_CNT_W,
  parameter int unsigned HALF_W = ftmr_pkg::FT_HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             tick,
  input  logic             bypass,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag
);
  localparam int unsigned NH = CNT_W / HALF_W;

  logic [NH-1:0]     inc;
  logic [HALF_W-1:0] part [NH];
  logic              ovf_set;

  for (genvar h = 0; h < NH; h++) begin : g_half
    if (h == 0) begin : g_lo
      assign inc[h] = bypass ? cnt_en : tick;
    end else begin : g_up
      assign inc[h] = bypass ? cnt_en : (inc[h-1] && (&part[h-1]));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      part[h] <= '0;
      else if (inc[h]) part[h] <= part[h] + HALF_W'(1);
    end
    assign count[h*HALF_W +: HALF_W] = part[h];
  end

  assign ovf_set = inc[NH-1] && (&part[NH-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (ovf_set) ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count));
  // R7
  top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && cnt_en && (&count[CNT_W-1 -: HALF_W])) |=> ovf_flag);
  // R6
  split_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && cnt_en) |=> (count[HALF_W-1:0] == $past(count[HALF_W-1:0]) + HALF_W'(1)));
  // R9
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !cnt_en) |=> !ovf_flag);
  // R5
  full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && tick && (&count)) |=> (ovf_flag && count == '0));
endmodule

// File: rtl/ftmr_top.sv
module ftmr_top #(
  parameter int unsigned CNT_W  = ftmr_pkg::FT_CNT_W,
  parameter int unsigned HALF_W = ftmr_pkg::FT_HALF_W,
  parameter int unsigned PS_W   = ftmr_pkg::FT_PS_W,
  parameter int unsigned REG_W  = ftmr_pkg::FT_REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [PS_W-1:0]  psel,
  input  logic             special_mode,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] rd_data,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  input  logic             ovf_clr
);
  logic tick;
  logic bypass;

  ftmr_testreg #(.REG_W(REG_W), .BYP_POS(ftmr_pkg::FT_BYP_POS)) u_treg (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .bypass(bypass));

  ftmr_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .psel(psel), .tick(tick));

  ftmr_counter #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .tick(tick), .bypass(bypass),
    .ovf_clr(ovf_clr), .count(count), .ovf_flag(ovf_flag));

  // R10
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && special_mode && !cnt_en) |=> $stable(count));
endmodule

// File: tb/ftmr_top_tb.sv
module ftmr_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic [2:0]  psel = '0;
  logic        special_mode = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  rd_data;
  logic [15:0] count;
  logic        ovf_flag;
  logic        ovf_clr = 1'b0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ftmr_top u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .psel(psel),
    .special_mode(special_mode), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .rd_data(rd_data), .count(count), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr));

  // {psel[2:0], bypass, enabled cycles[15:0], expected count[15:0]}
  localparam int NV = 7;
  localparam logic [35:0] VEC [NV] = '{
    {3'd0, 1'b0, 16'd10,  16'h000A},
    {3'd1, 1'b0, 16'd10,  16'h0005},
    {3'd2, 1'b0, 16'd10,  16'h0002},
    {3'd3, 1'b0, 16'd64,  16'h0008},
    {3'd7, 1'b0, 16'd300, 16'h0002},
    {3'd5, 1'b1, 16'd10,  16'h0A0A},
    {3'd0, 1'b1, 16'd300, 16'h2C2C}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d, input logic sm);
    reg_wr = 1'b1; reg_wdata = d; special_mode = sm;
    @(negedge clk);
    reg_wr = 1'b0; special_mode = 1'b0;
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R3 reset state
    chk("R3 count", count, 16'h0000);
    chk("R3 ovf", {15'd0, ovf_flag}, 16'd0);
    chk("R3 bypass", {8'd0, rd_data}, 16'h0000);

    // R4 R6 vector walk
    for (int i = 0; i < NV; i++) begin
      do_reset();
      psel = VEC[i][35:33];
      wr({7'd0, VEC[i][32]}, 1'b1);
      run(int'(VEC[i][31:16]));
      chk(VEC[i][32] ? "R6 split count" : "R4 prescaled count", count, VEC[i][15:0]);
    end

    // R2 write without special mode ignored; R1 read and reserved bits
    do_reset();
    wr(8'hFF, 1'b0);
    chk("R2 locked write", {8'd0, rd_data}, 16'h0000);
    wr(8'hFF, 1'b1);
    chk("R1 reserved zero", {8'd0, rd_data}, 16'h0001);
    wr(8'h00, 1'b1);
    chk("R2 write clears", {8'd0, rd_data}, 16'h0000);

    // R8 hold when disabled
    psel = 3'd0;
    run(5);
    repeat (6) @(negedge clk);
    chk("R8 hold", count, 16'h0005);

    // R5 low byte wrap does not set the flag
    do_reset();
    psel = 3'd0;
    run(256);
    chk("R5 low wrap count", count, 16'h0100);
    chk("R5 low wrap no flag", {15'd0, ovf_flag}, 16'd0);

    // R7 bypass high half wrap; R10 mode change keeps count; R5 full wrap
    do_reset();
    wr(8'h01, 1'b1);
    run(255);
    chk("R6 both halves", count, 16'hFFFF);
    chk("R7 no flag yet", {15'd0, ovf_flag}, 16'd0);
    wr(8'h00, 1'b1);
    chk("R10 count kept", count, 16'hFFFF);
    psel = 3'd0;
    run(1);
    chk("R5 full wrap count", count, 16'h0000);
    chk("R5 full wrap flag", {15'd0, ovf_flag}, 16'd1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R9 clear", {15'd0, ovf_flag}, 16'd0);

    // R6 no carry between halves, R7 high wrap in bypass
    do_reset();
    psel = 3'd0;
    run(3);
    wr(8'h01, 1'b1);
    chk("R10 into bypass", count, 16'h0003);
    run(253);
    chk("R6 no carry", count, 16'hFD00);
    chk("R7 low wrap no flag", {15'd0, ovf_flag}, 16'd0);
    run(3);
    chk("R7 high wrap count", count, 16'h0003);
    chk("R7 high wrap flag", {15'd0, ovf_flag}, 16'd1);

    // R9 set wins over clear
    do_reset();
    wr(8'h01, 1'b1);
    run(255);
    ovf_clr = 1'b1;
    run(1);
    ovf_clr = 1'b0;
    chk("R9 set wins", {15'd0, ovf_flag}, 16'd1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R9 clear after", {15'd0, ovf_flag}, 16'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule